// File: doc/BRIEF.md
# Logical Subtract, Compare and Exclusive-OR Execute Unit

This unit executes three unsigned operations of a 16-bit word-oriented processor: logical subtract, logical compare and bitwise exclusive-OR. Each operation comes in two forms. One form takes its second operand from a memory word that the surrounding pipeline has already fetched. The other form takes its second operand from a general register. The surrounding core decodes the instruction word and presents it to the unit. It also presents the first operand, which is the register named by bits 7:4, and both candidate second operands. The unit picks the correct second operand from the opcode, computes the result and keeps the three condition flags (zero, sign, overflow). It returns a write-back request for the destination register.

A small state machine sequences the work. In S_IDLE the unit waits. When an operation is accepted with a valid opcode, the machine moves to one of three states. Subtract and XOR go to S_WRITE, which presents a one-cycle write-back request. Compare goes to S_FLAGS, which updates the flags only and does no write. An unknown opcode goes to S_TRAP, which raises a one-cycle illegal-operation pulse. From any of these states, the next accepted operation takes the matching transition (GO_WRITE, GO_FLAGS, GO_TRAP). A cycle with no accepted operation takes RETIRE back to S_IDLE.

Top module: `lscx_unit`

## Requirements
- R1: While reset is asserted and after its release, the unit is idle. `wb_en`, `illegal`, `zf`, `sf` and `of` are all 0.
- R2: The opcode is `instr[15:8]`. 0x23 and 0x25 are subtract, 0x31 and 0x36 are XOR, and 0x41 and 0x44 are compare. 0x23, 0x31 and 0x41 use `mem_b` as the second operand. 0x25, 0x36 and 0x44 use `gr_b`.
- R3: `wb_idx` reports `instr[7:4]`, captured when the operation is accepted. `src_idx` combinationally reports `instr[3:0]`, the second register index for the register forms.
- R4: Subtract writes (a − b) mod 2^W. ZF is set when that result is zero. OF is set when a < b unsigned (borrow). SF is always 0, even when the result's top bit is set.
- R5: Compare never requests a write. ZF is set when a == b. SF is set when a < b unsigned. OF is 0.
- R6: XOR writes a ^ b. ZF is set when the result is zero. SF and OF are 0.
- R7: When `exec_en` is low at a clock edge, the flags keep their value and no write or trap follows.
- R8: An opcode outside R2 that is accepted gives `illegal` = 1 in the next cycle. That cycle has no write request, and the flags keep their value.
- R9: `wb_en` and `illegal` are high only in the cycle after an accepted operation. They are never high together, and the flags change in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Accept the presented operation at this edge |
| instr | input | 16 | Instruction word: opcode, destination index, source index |
| gr_a | input | W | First operand, the destination register's value |
| mem_b | input | W | Second operand for the memory forms |
| gr_b | input | W | Second operand for the register forms |
| src_idx | output | 4 | Register index of the second operand (instr[3:0]) |
| wb_en | output | 1 | Write-back request, one cycle |
| wb_idx | output | 4 | Destination register index |
| wb_data | output | W | Write-back value |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign / unsigned-less flag |
| of | output | 1 | Overflow / borrow flag |
| illegal | output | 1 | Unknown opcode was accepted, one cycle |

## Verification
The bench builds the unit with W = 4. This makes every pair of first and second operands reachable for each of the six valid opcodes, so all borrow, equality, wrap-around and zero-result cases of R4 to R6 are covered. During the sweep, the memory and register operands carry different values, so an operand-selection error shows up in the results. All 256 opcode values are also applied, which covers every illegal code, and idle cycles interleave with the sweep to exercise flag retention.

// File: rtl/lscx_pkg.sv
package lscx_pkg;
    localparam logic [7:0] OPC_SUB_MEM = 8'h23;
    localparam logic [7:0] OPC_SUB_REG = 8'h25;
    localparam logic [7:0] OPC_XOR_MEM = 8'h31;
    localparam logic [7:0] OPC_XOR_REG = 8'h36;
    localparam logic [7:0] OPC_CMP_MEM = 8'h41;
    localparam logic [7:0] OPC_CMP_REG = 8'h44;

    typedef enum logic [1:0] {K_SUB, K_XOR, K_CMP, K_NONE} op_kind_e;
    typedef enum logic [1:0] {S_IDLE, S_WRITE, S_FLAGS, S_TRAP} unit_state_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;
endpackage

// File: rtl/lscx_decode.sv
module lscx_decode
    import lscx_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind,
    output logic       use_reg
);
    always_comb begin
        kind    = K_NONE;
        use_reg = 1'b0;
        unique case (opcode)
            OPC_SUB_MEM: kind = K_SUB;
            OPC_SUB_REG: begin kind = K_SUB; use_reg = 1'b1; end
            OPC_XOR_MEM: kind = K_XOR;
            OPC_XOR_REG: begin kind = K_XOR; use_reg = 1'b1; end
            OPC_CMP_MEM: kind = K_CMP;
            OPC_CMP_REG: begin kind = K_CMP; use_reg = 1'b1; end
            default:     kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/lscx_alu.sv
module lscx_alu
    import lscx_pkg::*;
#(
    parameter int W = 16
) (
    input  op_kind_e       kind,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output flags_t         fl
);
    logic [W:0]   diff;
    logic         borrow;
    logic [W-1:0] xr;

    assign diff   = {1'b0, a} - {1'b0, b};
    assign borrow = diff[W];
    assign xr     = a ^ b;

    always_comb begin
        res = '0;
        fl  = '0;
        unique case (kind)
            K_SUB: begin
                res   = diff[W-1:0];
                fl.zf = (diff[W-1:0] == '0);
                fl.of = borrow;
            end
            K_XOR: begin
                res   = xr;
                fl.zf = (xr == '0);
            end
            K_CMP: begin
                fl.zf = (a == b);
                fl.sf = borrow;
            end
            default: begin
                res = '0;
                fl  = '0;
            end
        endcase
    end
endmodule

// File: rtl/lscx_unit.sv
module lscx_unit
    import lscx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_en,
    input  logic [15:0]  instr,
    input  logic [W-1:0] gr_a,
    input  logic [W-1:0] mem_b,
    input  logic [W-1:0] gr_b,
    output logic [3:0]   src_idx,
    output logic         wb_en,
    output logic [3:0]   wb_idx,
    output logic [W-1:0] wb_data,
    output logic         zf,
    output logic         sf,
    output logic         of,
    output logic         illegal
);
    op_kind_e     kind;
    logic         use_reg;
    logic [W-1:0] opnd_b;
    logic [W-1:0] alu_res;
    flags_t       alu_fl;
    flags_t       flags_q;
    logic [W-1:0] data_q;
    logic [3:0]   idx_q;
    unit_state_e  state_q, state_d;

    lscx_decode u_dec (
        .opcode (instr[15:8]),
        .kind   (kind),
        .use_reg(use_reg)
    );

    assign opnd_b  = use_reg ? gr_b : mem_b;
    assign src_idx = instr[3:0];

    lscx_alu #(.W(W)) u_alu (
        .kind(kind),
        .a   (gr_a),
        .b   (opnd_b),
        .res (alu_res),
        .fl  (alu_fl)
    );

    // Transitions: GO_WRITE, GO_FLAGS, GO_TRAP on accept; RETIRE otherwise.
    always_comb begin
        state_d = S_IDLE;
        if (exec_en) begin
            unique case (kind)
                K_SUB, K_XOR: state_d = S_WRITE;
                K_CMP:        state_d = S_FLAGS;
                default:      state_d = S_TRAP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            data_q  <= '0;
            idx_q   <= '0;
        end else if (exec_en && kind != K_NONE) begin
            flags_q <= alu_fl;
            data_q  <= alu_res;
            idx_q   <= instr[7:4];
        end
    end

    assign wb_en   = (state_q == S_WRITE);
    assign illegal = (state_q == S_TRAP);
    assign wb_idx  = idx_q;
    assign wb_data = data_q;
    assign zf      = flags_q.zf;
    assign sf      = flags_q.sf;
    assign of      = flags_q.of;
endmodule

// File: rtl/lscx_unit_chk.sv
module lscx_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exec_en,
    input logic [15:0] instr,
    input logic        wb_en,
    input logic        illegal,
    input logic        zf,
    input logic        sf,
    input logic        of
);
    logic is_sub, is_xor, is_cmp;
    assign is_sub = (instr[15:8] == 8'h23) || (instr[15:8] == 8'h25);
    assign is_xor = (instr[15:8] == 8'h31) || (instr[15:8] == 8'h36);
    assign is_cmp = (instr[15:8] == 8'h41) || (instr[15:8] == 8'h44);

    p_sub_sign_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && is_sub) |=> (wb_en && !sf));

    p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && is_cmp) |=> (!wb_en && !of && !illegal));

    p_xor_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && is_xor) |=> (wb_en && !sf && !of));

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> ($stable({zf, sf, of}) && !wb_en && !illegal));

    p_trap_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !is_sub && !is_xor && !is_cmp) |=> (illegal && !wb_en && $stable({zf, sf, of})));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, illegal}));
endmodule

bind lscx_unit lscx_unit_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .exec_en(exec_en),
    .instr  (instr),
    .wb_en  (wb_en),
    .illegal(illegal),
    .zf     (zf),
    .sf     (sf),
    .of     (of)
);

// File: tb/lscx_unit_tb.sv
module lscx_unit_tb;
    localparam int TW = 4;
    localparam int MASK = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exec_en = 1'b0;
    logic [15:0]   instr = '0;
    logic [TW-1:0] gr_a = '0, mem_b = '0, gr_b = '0;
    logic [3:0]    src_idx, wb_idx;
    logic          wb_en, zf, sf, of, illegal;
    logic [TW-1:0] wb_data;

    int n_chk = 0, n_bad = 0;
    logic m_zf = 0, m_sf = 0, m_of = 0;

    always #2 clk = ~clk;

    lscx_unit #(.W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
        .gr_a(gr_a), .mem_b(mem_b), .gr_b(gr_b), .src_idx(src_idx),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .zf(zf), .sf(sf), .of(of), .illegal(illegal)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one accepted operation, check the following cycle, then one idle cycle.
    task automatic run_op(input logic [7:0] opc, input int a, input int bm, input int br,
                          input int r, input int r2);
        int  b, res;
        bit  wr, bad;
        @(negedge clk);
        exec_en = 1'b1;
        instr = {opc, r[3:0], r2[3:0]};
        gr_a = a[TW-1:0]; mem_b = bm[TW-1:0]; gr_b = br[TW-1:0];
        #0;
        chk("R3 src_idx", int'(src_idx), r2);
        b = (opc == 8'h25 || opc == 8'h36 || opc == 8'h44) ? br : bm;
        wr = 0; bad = 0; res = 0;
        case (opc)
            8'h23, 8'h25: begin res = (a - b) & MASK; wr = 1;
                                m_zf = (res == 0); m_sf = 0; m_of = (a < b); end
            8'h31, 8'h36: begin res = (a ^ b) & MASK; wr = 1;
                                m_zf = (res == 0); m_sf = 0; m_of = 0; end
            8'h41, 8'h44: begin m_zf = (a == b); m_sf = (a < b); m_of = 0; end
            default: bad = 1;
        endcase
        @(negedge clk);
        exec_en = 1'b0;
        if (bad) begin
            chk("R8 illegal", int'(illegal), 1);
            chk("R8 no write", int'(wb_en), 0);
            chk("R8 flags held", int'({zf, sf, of}), int'({m_zf, m_sf, m_of}));
        end else begin
            chk("R9 illegal low", int'(illegal), 0);
            chk(wr ? "R4/R6 wb_en" : "R5 no write", int'(wb_en), int'(wr));
            if (wr) begin
                chk(opc[4] ? "R6 xor data" : "R4 sub data", int'(wb_data), res);
                chk("R3 wb_idx", int'(wb_idx), r);
            end
            chk(opc[6] ? "R5 cmp flags" : (opc[4] ? "R6 xor flags" : "R4 sub flags"),
                int'({zf, sf, of}), int'({m_zf, m_sf, m_of}));
        end
        @(negedge clk);
        chk("R9 pulse ends", int'({wb_en, illegal}), 0);
        chk("R7 flags hold idle", int'({zf, sf, of}), int'({m_zf, m_sf, m_of}));
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] ops [6];
        ops[0] = 8'h23; ops[1] = 8'h25; ops[2] = 8'h31;
        ops[3] = 8'h36; ops[4] = 8'h41; ops[5] = 8'h44;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({wb_en, illegal, zf, sf, of}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'({wb_en, illegal, zf, sf, of}), 0);

        // R2 R4 R5 R6: every operand pair; memory and register operands differ
        for (int k = 0; k < 6; k++)
            for (int a = 0; a <= MASK; a++)
                for (int b = 0; b <= MASK; b++)
                    run_op(ops[k], a, b, (~b) & MASK, a, b);

        // R7: operation presented without exec_en has no effect
        run_op(8'h25, 2, 0, 5, 1, 6);
        @(negedge clk);
        instr = {8'h23, 8'h10}; gr_a = 4'h3; mem_b = 4'h3;
        @(negedge clk);
        chk("R7 no write", int'({wb_en, illegal}), 0);
        chk("R7 flags unchanged", int'({zf, sf, of}), int'({m_zf, m_sf, m_of}));

        // R8: every opcode value, illegal ones trap
        for (int o = 0; o < 256; o++)
            run_op(o[7:0], o & MASK, (o >> 4) & MASK, (o >> 2) & MASK, o & 15, (o >> 4) & 15);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule